// File: doc/BRIEF.md
# Multi-Channel Result FIFO Bank

This block sits between a converter core and the system bus. It holds six separate four-deep queues of 16-bit conversion results. The converter side writes results in with one push strobe per queue. The bus side drains a queue by reading its pop register. Each queue is a ring of registers with a write pointer and a read pointer, so a push or a pop never shifts stored data.

Each queue shows its fill level and a not-empty flag. It also has a drain request that depends on a per-queue enable bit. A per-queue select bit routes that request to an interrupt line or to a DMA line. A push into a full queue is discarded, and the loss is recorded in a sticky overflow flag that is cleared by writing 1.

Top module: `result_fifo_bank`

## Requirements
- R1: The bank has six independent queues, numbered 0 to 5. Queue i takes its push data from `push_data[16i+15:16i]` and its push strobe from `push_valid[i]`. A read with `pop_sel` set to i addresses queue i. A read with `pop_sel` at 6 or 7 returns zero and changes no queue.
- R2: Each queue holds up to four 16-bit results and returns them oldest first, including when the pointers wrap past the last slot.
- R3: During a read cycle, `pop_data` presents the oldest entry of the selected queue. The pop takes effect at the clock edge that ends that cycle.
- R4: `not_empty[i]` is 1 exactly while queue i holds at least one entry. It changes in the cycle after the push or pop that changes the fill level.
- R5: The drain request of queue i is active only while queue i is not empty and `drain_en[i]` is 1.
- R6: When `dma_sel[i]` is 0, the drain request appears on `irq_req[i]` and `dma_req[i]` stays 0. When `dma_sel[i]` is 1, it appears on `dma_req[i]` and `irq_req[i]` stays 0.
- R7: A read is `pop_rd` high with any nonzero `pop_be`. Any nonzero byte-lane pattern pops exactly one entry and lowers the fill level by 1. `pop_rd` with `pop_be` equal to zero pops nothing.
- R8: A push and a pop on the same queue in the same cycle leave its fill level unchanged.
- R9: The fill level of queue i is a 3-bit value from 0 to 4, found at `count[3i+2:3i]`.
- R10: A push into a queue holding four entries is dropped and sets `overflow[i]`. The flag stays set until `ovf_clr[i]` is pulsed. When a set and a clear arrive in the same cycle, the set wins.
- R11: A read of an empty queue returns zero and leaves its pointers and fill level unchanged.
- R12: In DMA mode, `dma_req[i]` is low in the cycle after the pop that empties queue i.
- R13: After reset, all fill levels, not-empty flags, overflow flags and requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 6 | Push strobe per queue |
| push_data | input | 96 | Push data, 16 bits per queue |
| pop_rd | input | 1 | Bus read of a pop register |
| pop_sel | input | 3 | Queue addressed by the read |
| pop_be | input | 4 | Byte lanes of the read |
| pop_data | output | 16 | Read data, oldest entry of the selected queue |
| drain_en | input | 6 | Drain request enable per queue |
| dma_sel | input | 6 | 0 = interrupt, 1 = DMA per queue |
| ovf_clr | input | 6 | Write-1 clear of the overflow flags |
| count | output | 18 | Fill level, 3 bits per queue |
| not_empty | output | 6 | Queue holds at least one entry |
| overflow | output | 6 | Sticky overflow flag per queue |
| irq_req | output | 6 | Interrupt drain request per queue |
| dma_req | output | 6 | DMA drain request per queue |

## Verification
`pop_data` is combinational, so the bench checks it in the same cycle the read is driven, before the closing edge. Fill levels, flags and requests come from state that changes at that edge. They are due one cycle after the push, pop or clear that causes them. The bench drives each stimulus just after a rising edge and checks these outputs just after the following edge, which is the first point the new value can appear.

// File: rtl/result_fifo_bank.sv
module result_fifo_bank #(
  parameter int NF    = 6,
  parameter int DEPTH = 4,
  parameter int W     = 16,
  parameter int BEW   = 4,
  parameter int SELW  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NF-1:0]                push_valid,
  input  logic [NF*W-1:0]              push_data,
  input  logic                         pop_rd,
  input  logic [SELW-1:0]              pop_sel,
  input  logic [BEW-1:0]               pop_be,
  output logic [W-1:0]                 pop_data,
  input  logic [NF-1:0]                drain_en,
  input  logic [NF-1:0]                dma_sel,
  input  logic [NF-1:0]                ovf_clr,
  output logic [NF*$clog2(DEPTH+1)-1:0] count,
  output logic [NF-1:0]                not_empty,
  output logic [NF-1:0]                overflow,
  output logic [NF-1:0]                irq_req,
  output logic [NF-1:0]                dma_req
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wire rd = pop_rd && (|pop_be);

  logic [NF-1:0][W-1:0] head_w;
  logic [NF-1:0]        hit_w;

  for (genvar g = 0; g < NF; g++) begin : g_q
    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          ovf;

    wire full   = (cnt == CW'(DEPTH));
    wire hit    = rd && (pop_sel == SELW'(g)) && (cnt != '0);
    wire push   = push_valid[g] && !full;
    wire [AW-1:0] wp_nx = (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
    wire [AW-1:0] rp_nx = (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;

    always_ff @(posedge clk) begin
      if (push) slot[wp] <= push_data[g*W +: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        if (push) wp <= wp_nx;
        if (hit)  rp <= rp_nx;
        case ({push, hit})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
        if (push_valid[g] && full) ovf <= 1'b1;
        else if (ovf_clr[g])       ovf <= 1'b0;
      end
    end

    assign head_w[g]           = slot[rp];
    assign hit_w[g]            = hit;
    assign count[g*CW +: CW]   = cnt;
    assign not_empty[g]        = (cnt != '0);
    assign overflow[g]         = ovf;
    assign irq_req[g]          = not_empty[g] && drain_en[g] && !dma_sel[g];
    assign dma_req[g]          = not_empty[g] && drain_en[g] && dma_sel[g];

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
    a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && pop_sel == SELW'(g) && cnt == '0 && !push_valid[g]) |=> (cnt == '0 && $stable(rp)));
    a_r8_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && hit) |=> $stable(cnt));
    a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid[g] && full) |=> (ovf && cnt != '0));
    a_r12_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cnt == CW'(1) && !push_valid[g]) |=> !dma_req[g]);
  end

  always_comb begin
    pop_data = '0;
    for (int i = 0; i < NF; i++)
      if (hit_w[i]) pop_data = head_w[i];
  end

  a_r6_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & dma_req) == '0);
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w));
endmodule

// File: tb/result_fifo_bank_test.sv
module result_fifo_bank_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  push_valid = '0;
  logic [95:0] push_data = '0;
  logic        pop_rd = 1'b0;
  logic [2:0]  pop_sel = '0;
  logic [3:0]  pop_be = '0;
  logic [15:0] pop_data;
  logic [5:0]  drain_en = '0, dma_sel = '0, ovf_clr = '0;
  logic [17:0] count;
  logic [5:0]  not_empty, overflow, irq_req, dma_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  result_fifo_bank uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_rd(pop_rd), .pop_sel(pop_sel), .pop_be(pop_be), .pop_data(pop_data),
    .drain_en(drain_en), .dma_sel(dma_sel), .ovf_clr(ovf_clr), .count(count),
    .not_empty(not_empty), .overflow(overflow), .irq_req(irq_req), .dma_req(dma_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] cnt_of(input int i);
    return count[3*i +: 3];
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push1(input int i, input logic [15:0] d);
    push_valid[i] = 1'b1; push_data[16*i +: 16] = d;
    tick();
    push_valid[i] = 1'b0;
  endtask

  task automatic pop1(input string req, input int i, input logic [3:0] be, input logic [15:0] exp);
    pop_rd = 1'b1; pop_sel = 3'(i); pop_be = be;
    #1 check(req, pop_data, exp);
    tick();
    pop_rd = 1'b0; pop_be = '0;
  endtask

  task automatic t_reset();
    check("R13 count", count, 0);
    check("R13 not_empty", not_empty, 0);
    check("R13 overflow", overflow, 0);
    check("R13 reqs", {irq_req, dma_req}, 0);
  endtask

  task automatic t_order();
    push1(2, 16'hA001); push1(2, 16'hA002); push1(2, 16'hA003); push1(2, 16'hA004);
    check("R9 full level", cnt_of(2), 4);
    pop1("R2 R3 oldest", 2, 4'b0001, 16'hA001);
    check("R7 byte pop decrements", cnt_of(2), 3);
    pop1("R7 half pop", 2, 4'b0011, 16'hA002);
    pop1("R7 upper byte pop", 2, 4'b1000, 16'hA003);
    pop1("R7 word pop", 2, 4'b1111, 16'hA004);
    check("R7 level after four pops", cnt_of(2), 0);
    push1(2, 16'hB001); push1(2, 16'hB002);
    pop1("R2 wrap first", 2, 4'b1111, 16'hB001);
    pop1("R2 wrap second", 2, 4'b0100, 16'hB002);
  endtask

  task automatic t_indep();
    push_valid = 6'b100001;
    push_data[15:0] = 16'h1111; push_data[95:80] = 16'h5555;
    tick(); push_valid = '0;
    check("R1 levels", count, {3'd1, 12'd0, 3'd1});
    pop_rd = 1'b1; pop_sel = 3'd6; pop_be = 4'hF;
    #1 check("R1 sel 6 reads zero", pop_data, 0);
    tick(); pop_rd = 1'b0;
    check("R1 sel 6 no change", count, {3'd1, 12'd0, 3'd1});
    pop_rd = 1'b1; pop_sel = 3'd5; pop_be = 4'h0;
    tick(); pop_rd = 1'b0;
    check("R7 zero byte lanes no pop", cnt_of(5), 1);
    pop1("R1 queue 5 data", 5, 4'hF, 16'h5555);
    pop1("R1 queue 0 data", 0, 4'hF, 16'h1111);
    check("R1 all empty", count, 0);
  endtask

  task automatic t_req();
    push1(1, 16'hC0DE);
    check("R4 not_empty set", not_empty, 6'b000010);
    check("R5 no req when disabled", {irq_req, dma_req}, 0);
    drain_en[1] = 1'b1; dma_sel[1] = 1'b0; #1;
    check("R6 irq route", {irq_req, dma_req}, {6'b000010, 6'b0});
    dma_sel[1] = 1'b1; #1;
    check("R6 dma route", {irq_req, dma_req}, {6'b0, 6'b000010});
    pop1("R12 data", 1, 4'hF, 16'hC0DE);
    check("R12 dma low after emptying pop", dma_req[1], 0);
    check("R4 not_empty cleared", not_empty[1], 0);
    drain_en = '0; dma_sel = '0;
  endtask

  task automatic t_push_pop();
    push1(3, 16'hD001); push1(3, 16'hD002);
    push_valid[3] = 1'b1; push_data[63:48] = 16'hD003;
    pop_rd = 1'b1; pop_sel = 3'd3; pop_be = 4'hF;
    #1 check("R8 read during push", pop_data, 16'hD001);
    tick(); push_valid[3] = 1'b0; pop_rd = 1'b0;
    check("R8 level unchanged", cnt_of(3), 2);
    pop1("R8 order 2", 3, 4'hF, 16'hD002);
    pop1("R8 order 3", 3, 4'hF, 16'hD003);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 4; k++) push1(4, 16'hE000 + 16'(k));
    push1(4, 16'hEEEE);
    check("R10 overflow set", overflow, 6'b010000);
    check("R10 level stays 4", cnt_of(4), 4);
    for (int k = 0; k < 4; k++) pop1("R10 dropped push absent", 4, 4'hF, 16'hE000 + 16'(k));
    check("R10 sticky", overflow[4], 1);
    ovf_clr[4] = 1'b1; tick(); ovf_clr[4] = 1'b0;
    check("R10 cleared", overflow[4], 0);
    for (int k = 0; k < 4; k++) push1(4, 16'hF000);
    push_valid[4] = 1'b1; ovf_clr[4] = 1'b1;
    tick(); push_valid[4] = 1'b0; ovf_clr[4] = 1'b0;
    check("R10 set wins over clear", overflow[4], 1);
    for (int k = 0; k < 4; k++) pop1("R10 drain", 4, 4'hF, 16'hF000);
    ovf_clr[4] = 1'b1; tick(); ovf_clr[4] = 1'b0;
  endtask

  task automatic t_empty();
    pop1("R11 empty reads zero", 0, 4'hF, 16'h0000);
    check("R11 level unchanged", cnt_of(0), 0);
    push1(0, 16'h7777);
    pop1("R11 pointers intact", 0, 4'hF, 16'h7777);
    check("R11 empty again", cnt_of(0), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_indep();
    t_req();
    t_push_pop();
    t_overflow();
    t_empty();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule